// File: doc/BRIEF.md
# CCD Electronic Shutter Controller

This block decides, line by line, whether the substrate charge-discharge pulse of a CCD sensor fires, and so sets how long the sensor integrates before the next readout. It runs from the sync generator's strobes: a field boundary tick, a per-line tick and a readout event. From these it emits a one-cycle discharge pulse in the first lines after each readout. Every line that is swept this way is removed from the exposure. In the slow mode it instead holds readout off for whole fields.

The speed comes from one of two sources. In parallel mode, three static code pins pick one of eight fixed speeds. In serial mode, the same three pins act as strobe, clock and data and carry a 12-bit word: a 9-bit load value and a 2-bit mode. A separate trigger input can cut the discharge pulses short within a field, which gives continuously variable exposure. A global enable overrides everything. The standard select chooses between the 262-line / 60 Hz and 312-line / 50 Hz field timing.

Top module: `shutter_ctrl`

## Requirements
- R1: When `enb_i` is low at a line tick, no `xsub_o` pulse follows that line, whatever the other settings.
- R2: `xsub_o` is a one-cycle pulse in the cycle after a `line_tick_i`. Lines are numbered from 0, counting from the first line tick after `xsg_fall_i`. A pulse is emitted for line i only when i is below the active sweep count S. No pulse is emitted before the first readout event after reset, or on a line tick that coincides with a readout event.
- R3: With `par_sel_i` high, the code {ed0,ed1,ed2} selects the shutter speed: 111 gives no sweep, 101 gives 1/250, 001 gives 1/500, 110 gives 1/1000, 010 gives 1/2000, 100 gives 1/4000 and 000 gives 1/10000. For a speed 1/D, S = N − floor(N·F/D), where N=262 and F=60 when `std_625_i` is low, and N=312 and F=50 when it is high.
- R4: Flickerless speed (parallel code 011, or serial mode 00) uses D=100 when `std_625_i` is low and D=120 when it is high, in the same law.
- R5: With `par_sel_i` low, each rising edge of `ed1_i` while `ed0_i` is high shifts `ed2_i` into the receiver. The first bit sent lands in word bit 0. The falling edge of `ed0_i` commits the word. The bit order is load bits 0..8 (LSB first), then mode bit A, then mode bit B, then one dummy bit.
- R6: The serial mode {A,B} selects: 00 flickerless, 01 high-speed with S = 0x1FF − L, 10 low-speed, and 11 no shutter.
- R7: A serial load value of 0x1FF acts as 0x1FE.
- R8: In low-speed mode, `read_en_o` is low for n−1 fields and then high for one, with n = 2·(0x1FF − L) and S = 0. In all other modes it is high in every field. It changes only in the cycle after a `field_tick_i`.
- R9: Parallel code 111 and serial mode 11 produce no `xsub_o` pulse.
- R10: A falling edge on `trig_i` suppresses `xsub_o` on every later line until the next `xsg_fall_i`. The falling edge is sampled one cycle before the line tick of line k, and suppression starts at line k.
- R11: Pin settings and a committed serial word take effect only at the next `field_tick_i`. A word committed mid-field leaves the current field unchanged.
- R12: After reset, `xsub_o` is low and `read_en_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| std_625_i | input | 1 | 0: 262-line/60 Hz timing, 1: 312-line/50 Hz timing |
| field_tick_i | input | 1 | One-cycle field boundary strobe |
| line_tick_i | input | 1 | One-cycle line strobe |
| xsg_fall_i | input | 1 | One-cycle readout event strobe |
| enb_i | input | 1 | Shutter enable; low blocks all pulses |
| par_sel_i | input | 1 | 1: parallel code, 0: serial word |
| ed0_i | input | 1 | Code bit / serial strobe |
| ed1_i | input | 1 | Code bit / serial clock |
| ed2_i | input | 1 | Code bit / serial data |
| trig_i | input | 1 | Trigger; falling edge ends sweeping for the field |
| xsub_o | output | 1 | Charge-discharge pulse, one cycle per swept line |
| read_en_o | output | 1 | Readout allowed in the current field |

## Verification
The bench builds the block with its default parameters: 262 and 312 lines per field at 60 and 50 Hz, and a 10-bit line counter. It runs fields long enough to exceed the largest sweep count, so the 1/10000 case reaches line 261 and the 625-line 1/1000 case reaches line 297. The end of every sweep window is therefore observed, not just its start. Short serial load values keep the low-speed field counts at 2 and 4, so the full readout-skip cycle is covered within a few fields.

// File: rtl/shutter_pkg.sv
package shutter_pkg;
  localparam int WORD_W = 12;
  localparam int LOAD_W = 9;

  typedef enum logic [1:0] {
    MODE_FLICK = 2'b00,
    MODE_HIGH  = 2'b01,
    MODE_LOW   = 2'b10,
    MODE_OFF   = 2'b11
  } smode_e;

  // lines removed from a field of `lines` at rate `rate` for speed 1/div
  function automatic int sweep_of(int lines, int rate, int div);
    return lines - (lines * rate) / div;
  endfunction
endpackage

// File: rtl/shutter_serial_rx.sv
module shutter_serial_rx #(
  parameter int WORD_W = shutter_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_i,
  input  logic              sck_i,
  input  logic              sdat_i,
  output logic [WORD_W-1:0] word_o
);
  logic              stb_q, sck_q;
  logic [WORD_W-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= 1'b0;
      sck_q   <= 1'b0;
      shreg_q <= '1;
      word_o  <= '1;
    end else begin
      stb_q <= stb_i;
      sck_q <= sck_i;
      if (en_i && stb_i && sck_i && !sck_q)
        shreg_q <= {sdat_i, shreg_q[WORD_W-1:1]};
      if (en_i && stb_q && !stb_i)
        word_o <= shreg_q;
    end
  end
endmodule

// File: rtl/shutter_speed_dec.sv
module shutter_speed_dec
  import shutter_pkg::*;
#(
  parameter int LINES_525 = 262,
  parameter int RATE_525  = 60,
  parameter int LINES_625 = 312,
  parameter int RATE_625  = 50,
  parameter int CNT_W     = 10
) (
  input  logic              par_sel_i,
  input  logic              std_i,
  input  logic [2:0]        code_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  sweep_o,
  output logic              low_o,
  output logic [CNT_W-1:0]  nfld_o
);
  localparam logic [LOAD_W-1:0] LOAD_MAX = '1;

  function automatic logic [CNT_W-1:0] pick(logic s, int div);
    return s ? CNT_W'(sweep_of(LINES_625, RATE_625, div))
             : CNT_W'(sweep_of(LINES_525, RATE_525, div));
  endfunction

  logic [LOAD_W-1:0] load, diff;
  logic [CNT_W-1:0]  flick_sw;
  smode_e            mode;

  always_comb begin
    load     = word_i[LOAD_W-1:0];
    if (load == LOAD_MAX) load = LOAD_MAX - 1'b1;
    diff     = LOAD_MAX - load;
    mode     = smode_e'({word_i[LOAD_W], word_i[LOAD_W+1]});
    flick_sw = std_i ? pick(1'b1, 120) : pick(1'b0, 100);
    sweep_o  = '0;
    low_o    = 1'b0;
    nfld_o   = '0;
    if (par_sel_i) begin
      unique case (code_i)
        3'b111:  sweep_o = '0;
        3'b011:  sweep_o = flick_sw;
        3'b101:  sweep_o = pick(std_i, 250);
        3'b001:  sweep_o = pick(std_i, 500);
        3'b110:  sweep_o = pick(std_i, 1000);
        3'b010:  sweep_o = pick(std_i, 2000);
        3'b100:  sweep_o = pick(std_i, 4000);
        default: sweep_o = pick(std_i, 10000);
      endcase
    end else begin
      unique case (mode)
        MODE_FLICK: sweep_o = flick_sw;
        MODE_HIGH:  sweep_o = CNT_W'(diff);
        MODE_LOW: begin
          low_o  = 1'b1;
          nfld_o = CNT_W'({diff, 1'b0});
        end
        default:    sweep_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/shutter_field_seq.sv
module shutter_field_seq #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             field_tick_i,
  input  logic             low_i,
  input  logic [CNT_W-1:0] nfld_i,
  output logic             read_en_o
);
  logic [CNT_W-1:0] fcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fcnt_q    <= '0;
      read_en_o <= 1'b1;
    end else if (field_tick_i) begin
      if (low_i && (fcnt_q + 1'b1 < nfld_i)) begin
        fcnt_q    <= fcnt_q + 1'b1;
        read_en_o <= 1'b0;
      end else begin
        fcnt_q    <= '0;
        read_en_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/shutter_ctrl.sv
module shutter_ctrl #(
  parameter int LINES_525 = 262,
  parameter int RATE_525  = 60,
  parameter int LINES_625 = 312,
  parameter int RATE_625  = 50,
  parameter int CNT_W     = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic std_625_i,
  input  logic field_tick_i,
  input  logic line_tick_i,
  input  logic xsg_fall_i,
  input  logic enb_i,
  input  logic par_sel_i,
  input  logic ed0_i,
  input  logic ed1_i,
  input  logic ed2_i,
  input  logic trig_i,
  output logic xsub_o,
  output logic read_en_o
);
  import shutter_pkg::*;

  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  dec_sweep, dec_nfld, sweep_q, line_cnt_q;
  logic              dec_low, trig_q, supp_q;

  shutter_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (!par_sel_i),
    .stb_i  (ed0_i),
    .sck_i  (ed1_i),
    .sdat_i (ed2_i),
    .word_o (word)
  );

  shutter_speed_dec #(
    .LINES_525(LINES_525), .RATE_525(RATE_525),
    .LINES_625(LINES_625), .RATE_625(RATE_625), .CNT_W(CNT_W)
  ) u_dec (
    .par_sel_i (par_sel_i),
    .std_i     (std_625_i),
    .code_i    ({ed0_i, ed1_i, ed2_i}),
    .word_i    (word),
    .sweep_o   (dec_sweep),
    .low_o     (dec_low),
    .nfld_o    (dec_nfld)
  );

  shutter_field_seq #(.CNT_W(CNT_W)) u_fld (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .field_tick_i (field_tick_i),
    .low_i        (dec_low),
    .nfld_i       (dec_nfld),
    .read_en_o    (read_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sweep_q    <= '0;
      line_cnt_q <= '1;
      trig_q     <= 1'b1;
      supp_q     <= 1'b0;
      xsub_o     <= 1'b0;
    end else begin
      trig_q <= trig_i;
      if (field_tick_i) sweep_q <= dec_sweep;
      if (xsg_fall_i) begin
        line_cnt_q <= '0;
        supp_q     <= 1'b0;
      end else begin
        if (line_tick_i && line_cnt_q != '1) line_cnt_q <= line_cnt_q + 1'b1;
        if (trig_q && !trig_i) supp_q <= 1'b1;
      end
      xsub_o <= line_tick_i && !xsg_fall_i && enb_i && !supp_q &&
                (line_cnt_q < sweep_q);
    end
  end
endmodule

// File: rtl/shutter_ctrl_chk.sv
module shutter_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic enb_i,
  input logic line_tick_i,
  input logic xsg_fall_i,
  input logic field_tick_i,
  input logic trig_i,
  input logic xsub_o,
  input logic read_en_o
);
  p_enb_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xsub_o |-> $past(enb_i));

  p_line_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xsub_o |-> ($past(line_tick_i) && !$past(xsg_fall_i)));

  p_read_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(field_tick_i) |-> $stable(read_en_o));

  p_trig_cut_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(trig_i, 2) && !$past(trig_i) && !$past(xsg_fall_i)) |=> !xsub_o);
endmodule

bind shutter_ctrl shutter_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enb_i        (enb_i),
  .line_tick_i  (line_tick_i),
  .xsg_fall_i   (xsg_fall_i),
  .field_tick_i (field_tick_i),
  .trig_i       (trig_i),
  .xsub_o       (xsub_o),
  .read_en_o    (read_en_o)
);

// File: tb/shutter_ctrl_tb_top.sv
module shutter_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic std_625_i = 1'b0, field_tick_i = 1'b0, line_tick_i = 1'b0, xsg_fall_i = 1'b0;
  logic enb_i = 1'b1, par_sel_i = 1'b1, ed0_i = 1'b1, ed1_i = 1'b1, ed2_i = 1'b1;
  logic trig_i = 1'b1;
  logic xsub_o, read_en_o;

  int n_chk = 0, n_bad = 0;
  bit   exp_q[$];
  string tag_q[$];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  shutter_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .std_625_i(std_625_i),
    .field_tick_i(field_tick_i), .line_tick_i(line_tick_i),
    .xsg_fall_i(xsg_fall_i), .enb_i(enb_i), .par_sel_i(par_sel_i),
    .ed0_i(ed0_i), .ed1_i(ed1_i), .ed2_i(ed2_i), .trig_i(trig_i),
    .xsub_o(xsub_o), .read_en_o(read_en_o)
  );

  function automatic int sw(bit s, int div);
    int n = s ? 312 : 262;
    int f = s ? 50 : 60;
    return n - (n * f) / div;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: one compare per line tick, one cycle later
  initial begin
    forever begin
      @(posedge clk);
      if (line_tick_i) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("R2 unexpected line", 1, 0);
        else begin
          string t = tag_q.pop_front();
          check(t, int'(xsub_o), int'(exp_q.pop_front()));
        end
      end
    end
  end

  task automatic begin_field(bit exp_rd, string req);
    @(negedge clk); field_tick_i = 1'b1;
    @(negedge clk); field_tick_i = 1'b0; xsg_fall_i = 1'b1;
    check(req, int'(read_en_o), int'(exp_rd));
    @(negedge clk); xsg_fall_i = 1'b0;
  endtask

  task automatic run_lines(int n, int s, int trig_line, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == trig_line) trig_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_q.push_back(enb_i && !(trig_line >= 0 && i >= trig_line) && i < s);
      tag_q.push_back(req);
      line_tick_i = 1'b1;
      @(negedge clk); line_tick_i = 1'b0;
    end
    @(negedge clk); @(negedge clk);
    trig_i = 1'b1;
  endtask

  task automatic send_word(logic [8:0] load, bit a, bit b);
    logic [11:0] w = {1'b0, b, a, load};
    @(negedge clk); ed0_i = 1'b1; ed1_i = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); ed2_i = w[k]; ed1_i = 1'b0;
      @(negedge clk); ed1_i = 1'b1;
    end
    @(negedge clk); ed1_i = 1'b0;
    @(negedge clk); ed0_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_code(logic [2:0] c);
    @(negedge clk); {ed0_i, ed1_i, ed2_i} = c;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R12 xsub reset", int'(xsub_o), 0);
    check("R12 read_en reset", int'(read_en_o), 1);
    run_lines(6, 0, -1, "R2 before readout");

    set_code(3'b111); begin_field(1, "R8"); run_lines(10, 0, -1, "R9 code 111");
    set_code(3'b011); begin_field(1, "R8"); run_lines(110, sw(0, 100), -1, "R4 flick 525");
    set_code(3'b000); begin_field(1, "R8"); run_lines(265, sw(0, 10000), -1, "R3 1/10000");
    set_code(3'b101); begin_field(1, "R8"); run_lines(205, sw(0, 250), -1, "R3 1/250");
    std_625_i = 1'b1;
    set_code(3'b011); begin_field(1, "R8"); run_lines(190, sw(1, 120), -1, "R4 flick 625");
    set_code(3'b110); begin_field(1, "R8"); run_lines(300, sw(1, 1000), -1, "R3 1/1000 625");
    std_625_i = 1'b0;
    set_code(3'b000); enb_i = 1'b0;
    begin_field(1, "R8"); run_lines(20, 0, -1, "R1 enb low");
    enb_i = 1'b1;
    begin_field(1, "R8"); run_lines(60, sw(0, 10000), 50, "R10 trig cut");
    begin_field(1, "R8"); run_lines(60, sw(0, 10000), -1, "R10 cleared");

    par_sel_i = 1'b0;
    send_word(9'h1F0, 1'b0, 1'b1);
    begin_field(1, "R8"); run_lines(20, 15, -1, "R5 R6 high speed");
    begin_field(1, "R8");
    send_word(9'h1F8, 1'b0, 1'b1);
    run_lines(20, 15, -1, "R11 old word kept");
    begin_field(1, "R8"); run_lines(20, 7, -1, "R11 new word");
    send_word(9'h1FF, 1'b0, 1'b1);
    begin_field(1, "R8"); run_lines(5, 1, -1, "R7 clamp");
    send_word(9'h000, 1'b0, 1'b0);
    begin_field(1, "R8"); run_lines(110, sw(0, 100), -1, "R6 serial flick");
    send_word(9'h1F0, 1'b1, 1'b1);
    begin_field(1, "R8"); run_lines(10, 0, -1, "R9 no shutter");
    send_word(9'h1FE, 1'b1, 1'b0);
    for (int f = 0; f < 4; f++) begin
      begin_field(f % 2 == 1, "R8 n=2");
      run_lines(4, 0, -1, "R8 low no sweep");
    end
    send_word(9'h1FD, 1'b1, 1'b0);
    for (int f = 0; f < 4; f++) begin
      begin_field(f == 3, "R8 n=4");
      run_lines(4, 0, -1, "R8 low no sweep");
    end
    repeat (4) @(negedge clk);
    check("R2 queue drained", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule